// File: doc/BRIEF.md
# Debounced Edge Interrupt Detector

This block watches six already-synchronous input pins: a power button, three keyboard keys, an AC-present line and the embedded controller's reset line. On each pin it looks for level changes. Software chooses, for each pin on its own, whether a high-to-low change, a low-to-high change, both or neither should be reported. A button press shows up as a high-to-low change and a release as a low-to-high change.

A change is only believed once the new level has held for a programmable number of clock cycles. One debounce value serves all six pins, but every pin runs its own counter. If the pin goes back to its old level before the count is reached, the candidate change is thrown away. A change that survives sets a sticky cause bit for that pin and direction. Software clears these bits by writing ones to them. All cause bits are combined into one interrupt line.

Pin index order is fixed: 0 power button, 1 to 3 keys, 4 AC-present, 5 embedded-controller reset.

Top module: `edge_irq_detect`

## Requirements
- R1: After reset, `status_o` and `irq_o` are 0. Every pin's accepted level is 1, so a pin that starts at 1 produces no event.
- R2: A 1-to-0 change on pin i sets `status_o[i]` when `cfg_fall_en_i[i]` is 1 at the qualifying edge. Bits [5:0] hold the high-to-low causes.
- R3: A 0-to-1 change on pin i sets `status_o[6+i]` when `cfg_rise_en_i[i]` is 1 at the qualifying edge. Bits [11:6] hold the low-to-high causes.
- R4: A change in a direction whose enable is 0 still goes through debounce and updates the pin's accepted level. It sets no status bit. A later change in the enabled direction is still reported.
- R5: If the pin returns to its accepted level at any sampled edge before qualification, the candidate change is discarded and nothing is set.
- R6: Let D be `cfg_debounce_i` and let edge t0 be the first edge that samples the new level. The bit is visible after edge t0+D+1, provided the new level is sampled at every edge from t0 to t0+D+1. A new level held for only D+1 edges sets nothing.
- R7: Status bits stay set until cleared. With `clr_valid_i` high, every bit set to 1 in `clr_mask_i` is cleared at the next edge. Bits outside the mask are untouched.
- R8: If a new event and a clear hit the same bit in the same cycle, the bit stays set.
- R9: `irq_o` is 1 exactly when at least one status bit is 1. It changes in the same cycle as the status bits.
- R10: The pins are independent. Changes on several pins at the same edge each set their own bit in the same cycle.
- R11: With D = 0, a new level sampled at two consecutive edges is enough to qualify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_fall_en_i | input | 6 | Per-pin enable for high-to-low reporting |
| cfg_rise_en_i | input | 6 | Per-pin enable for low-to-high reporting |
| cfg_debounce_i | input | 16 | Shared debounce count D, in clock cycles |
| clr_valid_i | input | 1 | Clear strobe |
| clr_mask_i | input | 12 | Write-one-to-clear mask, same layout as `status_o` |
| pins_i | input | 6 | Synchronous input pins |
| status_o | output | 12 | Sticky cause bits: [5:0] high-to-low, [11:6] low-to-high |
| irq_o | output | 1 | OR of all cause bits |

## Verification
The hardest case to reach from the ports is a qualification and a clear landing on the same bit in the same cycle. It needs a press timed so that its final debounce edge matches the clear strobe exactly. The stimulus table counts edges from the first low sample and places the clear on that exact vector. It also clears an older bit in the same write, to show which of the two wins.

The table also covers:
- a glitch that returns after two edges;
- a press that is one edge too short;
- silent debounce of a disabled direction followed by an enabled one.

Directed tests then cover D = 0, a wider D window checked on its last short edge, and several pins qualifying together.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

    // Debounce state of one pin channel
    typedef enum logic {
        CH_IDLE = 1'b0,   // pin agrees with accepted level
        CH_QUAL = 1'b1    // candidate change being timed
    } ch_mode_e;

endpackage

// File: rtl/edge_irq_chan.sv
module edge_irq_chan
    import edge_irq_pkg::*;
#(
    parameter int   CNT_W      = 16,
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pin_i,
    input  logic             fall_en_i,
    input  logic             rise_en_i,
    input  logic [CNT_W-1:0] debounce_i,
    output logic             fall_hit_o,
    output logic             rise_hit_o
);

    typedef struct packed {
        ch_mode_e         mode;
        logic             level;
        logic [CNT_W-1:0] cnt;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic        fall_hit_d, rise_hit_d;

    always_comb begin
        st_d       = st_q;
        fall_hit_d = 1'b0;
        rise_hit_d = 1'b0;
        unique case (st_q.mode)
            CH_IDLE: begin
                if (pin_i != st_q.level) begin
                    st_d.mode = CH_QUAL;
                    st_d.cnt  = '0;
                end
            end
            CH_QUAL: begin
                if (pin_i == st_q.level) begin
                    // glitch: drop the candidate
                    st_d.mode = CH_IDLE;
                end else if (st_q.cnt >= debounce_i) begin
                    st_d.mode  = CH_IDLE;
                    st_d.level = pin_i;
                    fall_hit_d = ~pin_i & fall_en_i;
                    rise_hit_d =  pin_i & rise_en_i;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            default: st_d.mode = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{mode: CH_IDLE, level: IDLE_LEVEL, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign fall_hit_o = fall_hit_d;
    assign rise_hit_o = rise_hit_d;

endmodule

// File: rtl/edge_irq_status.sv
module edge_irq_status #(
    parameter int WIDTH = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] set_i,
    input  logic             clr_valid_i,
    input  logic [WIDTH-1:0] clr_mask_i,
    output logic [WIDTH-1:0] status_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [WIDTH-1:0] bits;
        logic             irq;
    } stat_t;

    stat_t            s_d, s_q;
    logic [WIDTH-1:0] clr_eff;

    always_comb begin
        clr_eff  = clr_valid_i ? clr_mask_i : '0;
        // set has priority over a clear in the same cycle
        s_d.bits = (s_q.bits & ~clr_eff) | set_i;
        s_d.irq  = |s_d.bits;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign status_o = s_q.bits;
    assign irq_o    = s_q.irq;

endmodule

// File: rtl/edge_irq_detect.sv
module edge_irq_detect #(
    parameter int                NUM_IN     = 6,
    parameter int                CNT_W      = 16,
    parameter logic [NUM_IN-1:0] IDLE_LEVEL = '1
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [NUM_IN-1:0]     cfg_fall_en_i,
    input  logic [NUM_IN-1:0]     cfg_rise_en_i,
    input  logic [CNT_W-1:0]      cfg_debounce_i,
    input  logic                  clr_valid_i,
    input  logic [2*NUM_IN-1:0]   clr_mask_i,
    input  logic [NUM_IN-1:0]     pins_i,
    output logic [2*NUM_IN-1:0]   status_o,
    output logic                  irq_o
);

    localparam int StatW = 2 * NUM_IN;

    logic [NUM_IN-1:0] fall_hit;
    logic [NUM_IN-1:0] rise_hit;
    logic [StatW-1:0]  set_vec;

    for (genvar g = 0; g < NUM_IN; g++) begin : g_chan
        edge_irq_chan #(
            .CNT_W      (CNT_W),
            .IDLE_LEVEL (IDLE_LEVEL[g])
        ) i_chan (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .pin_i      (pins_i[g]),
            .fall_en_i  (cfg_fall_en_i[g]),
            .rise_en_i  (cfg_rise_en_i[g]),
            .debounce_i (cfg_debounce_i),
            .fall_hit_o (fall_hit[g]),
            .rise_hit_o (rise_hit[g])
        );
    end

    assign set_vec = {rise_hit, fall_hit};

    edge_irq_status #(
        .WIDTH (StatW)
    ) i_status (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .set_i       (set_vec),
        .clr_valid_i (clr_valid_i),
        .clr_mask_i  (clr_mask_i),
        .status_o    (status_o),
        .irq_o       (irq_o)
    );

endmodule

// File: rtl/edge_irq_checker.sv
module edge_irq_checker #(
    parameter int NUM_IN = 6
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic [NUM_IN-1:0]   cfg_fall_en_i,
    input logic [NUM_IN-1:0]   cfg_rise_en_i,
    input logic                clr_valid_i,
    input logic [2*NUM_IN-1:0] clr_mask_i,
    input logic [NUM_IN-1:0]   pins_i,
    input logic [2*NUM_IN-1:0] status_o,
    input logic                irq_o
);

    logic [2*NUM_IN-1:0] clr_eff;
    assign clr_eff = clr_valid_i ? clr_mask_i : '0;

    for (genvar i = 0; i < NUM_IN; i++) begin : g_bit
        // R2 / R4: a falling cause only appears with its enable and a low pin
        assert_fall_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(status_o[i]) |-> ($past(cfg_fall_en_i[i]) && !$past(pins_i[i])));
        // R3 / R4: a rising cause only appears with its enable and a high pin
        assert_rise_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(status_o[NUM_IN+i]) |-> ($past(cfg_rise_en_i[i]) && $past(pins_i[i])));
        // R6: a qualified level was sampled on at least two consecutive edges
        assert_hold_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(status_o[i]) |-> ($past(pins_i[i], 2) == $past(pins_i[i])));
        assert_hold_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(status_o[NUM_IN+i]) |-> ($past(pins_i[i], 2) == $past(pins_i[i])));
    end

    // R7: set bits not targeted by a clear remain set
    assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((status_o & ~clr_eff) != '0) |=> (($past(status_o) & ~$past(clr_eff) & ~status_o) == '0));

    // R9: the interrupt only drops after a clear request
    assert_irq_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(irq_o) |-> $past(clr_valid_i));

endmodule

bind edge_irq_detect edge_irq_checker #(.NUM_IN(NUM_IN)) i_edge_irq_checker (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cfg_fall_en_i (cfg_fall_en_i),
    .cfg_rise_en_i (cfg_rise_en_i),
    .clr_valid_i   (clr_valid_i),
    .clr_mask_i    (clr_mask_i),
    .pins_i        (pins_i),
    .status_o      (status_o),
    .irq_o         (irq_o)
);

// File: tb/test_edge_irq_detect.sv
module test_edge_irq_detect;

    logic        clk = 1'b0;
    logic        rst_ni;
    logic [5:0]  fall_en, rise_en;
    logic [15:0] deb;
    logic        clr_v;
    logic [11:0] clr_m;
    logic [5:0]  pins;
    logic [11:0] status;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    edge_irq_detect i_edge_irq_detect (
        .clk_i          (clk),
        .rst_ni         (rst_ni),
        .cfg_fall_en_i  (fall_en),
        .cfg_rise_en_i  (rise_en),
        .cfg_debounce_i (deb),
        .clr_valid_i    (clr_v),
        .clr_mask_i     (clr_m),
        .pins_i         (pins),
        .status_o       (status),
        .irq_o          (irq)
    );

    // {tag[34:31], pins[30:25], clr[24], mask[23:12], expected status[11:0]}
    // Expected status is the value seen after the edge that consumes the vector.
    // Config: fall enables 011111, rise enables 101111, D = 2.
    localparam int NV = 50;
    localparam logic [34:0] VEC [NV] = '{
        {4'd1,  6'h3F, 1'b0, 12'h000, 12'h000},  // R1 idle after reset
        {4'd2,  6'h3E, 1'b0, 12'h000, 12'h000},  // R2 pin0 low, t0
        {4'd2,  6'h3E, 1'b0, 12'h000, 12'h000},
        {4'd6,  6'h3E, 1'b0, 12'h000, 12'h000},  // R6 not yet at t0+2
        {4'd2,  6'h3E, 1'b0, 12'h000, 12'h001},  // R2 qualifies at t0+3
        {4'd3,  6'h3F, 1'b0, 12'h000, 12'h001},  // R3 release, t0
        {4'd3,  6'h3F, 1'b0, 12'h000, 12'h001},
        {4'd3,  6'h3F, 1'b0, 12'h000, 12'h001},
        {4'd3,  6'h3F, 1'b0, 12'h000, 12'h041},  // R3 rise bit 6
        {4'd7,  6'h3F, 1'b1, 12'h001, 12'h040},  // R7 only masked bit clears
        {4'd7,  6'h3F, 1'b1, 12'h040, 12'h000},
        {4'd5,  6'h3D, 1'b0, 12'h000, 12'h000},  // R5 glitch on pin1
        {4'd5,  6'h3D, 1'b0, 12'h000, 12'h000},
        {4'd5,  6'h3F, 1'b0, 12'h000, 12'h000},
        {4'd5,  6'h3F, 1'b0, 12'h000, 12'h000},
        {4'd5,  6'h3F, 1'b0, 12'h000, 12'h000},
        {4'd6,  6'h3B, 1'b0, 12'h000, 12'h000},  // R6 pin2 held D+1 edges only
        {4'd6,  6'h3B, 1'b0, 12'h000, 12'h000},
        {4'd6,  6'h3B, 1'b0, 12'h000, 12'h000},
        {4'd6,  6'h3F, 1'b0, 12'h000, 12'h000},
        {4'd6,  6'h3F, 1'b0, 12'h000, 12'h000},
        {4'd4,  6'h1F, 1'b0, 12'h000, 12'h000},  // R4 pin5 fall disabled
        {4'd4,  6'h1F, 1'b0, 12'h000, 12'h000},
        {4'd4,  6'h1F, 1'b0, 12'h000, 12'h000},
        {4'd4,  6'h1F, 1'b0, 12'h000, 12'h000},
        {4'd4,  6'h1F, 1'b0, 12'h000, 12'h000},
        {4'd4,  6'h3F, 1'b0, 12'h000, 12'h000},  // R4 pin5 rise enabled
        {4'd4,  6'h3F, 1'b0, 12'h000, 12'h000},
        {4'd4,  6'h3F, 1'b0, 12'h000, 12'h000},
        {4'd4,  6'h3F, 1'b0, 12'h000, 12'h800},
        {4'd9,  6'h3F, 1'b0, 12'h000, 12'h800},
        {4'd8,  6'h37, 1'b0, 12'h000, 12'h800},  // R8 pin3 press
        {4'd8,  6'h37, 1'b0, 12'h000, 12'h800},
        {4'd8,  6'h37, 1'b0, 12'h000, 12'h800},
        {4'd8,  6'h37, 1'b1, 12'h808, 12'h008},  // R8 set wins over clear
        {4'd8,  6'h37, 1'b0, 12'h000, 12'h008},
        {4'd7,  6'h37, 1'b1, 12'h008, 12'h000},
        {4'd2,  6'h27, 1'b0, 12'h000, 12'h000},  // R2 pin4 low
        {4'd2,  6'h27, 1'b0, 12'h000, 12'h000},
        {4'd2,  6'h27, 1'b0, 12'h000, 12'h000},
        {4'd2,  6'h27, 1'b0, 12'h000, 12'h010},
        {4'd4,  6'h37, 1'b0, 12'h000, 12'h010},  // R4 pin4 rise disabled
        {4'd4,  6'h37, 1'b0, 12'h000, 12'h010},
        {4'd4,  6'h37, 1'b0, 12'h000, 12'h010},
        {4'd4,  6'h37, 1'b0, 12'h000, 12'h010},
        {4'd3,  6'h3F, 1'b1, 12'h010, 12'h000},  // R3 pin3 release + clear
        {4'd3,  6'h3F, 1'b0, 12'h000, 12'h000},
        {4'd3,  6'h3F, 1'b0, 12'h000, 12'h000},
        {4'd3,  6'h3F, 1'b0, 12'h000, 12'h200},
        {4'd9,  6'h3F, 1'b0, 12'h000, 12'h200}   // R9 irq follows status
    };

    task automatic check(input int tag, input logic [11:0] exp);
        logic exp_irq;
        exp_irq = (exp != 12'h000);  // R9
        checks++;
        if (status !== exp || irq !== exp_irq) begin
            fails++;
            $display("FAIL R%0d: status=%h irq=%b expected status=%h irq=%b",
                     tag, status, irq, exp, exp_irq);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        rst_ni  = 1'b0;
        fall_en = 6'b011111;
        rise_en = 6'b101111;
        deb     = 16'd2;
        clr_v   = 1'b0;
        clr_m   = '0;
        pins    = 6'h3F;
        repeat (3) @(negedge clk);
        check(1, 12'h000);  // R1 during reset
        rst_ni = 1'b1;

        for (int k = 0; k < NV; k++) begin
            pins  = VEC[k][30:25];
            clr_v = VEC[k][24];
            clr_m = VEC[k][23:12];
            step();
            check(int'(VEC[k][34:31]), VEC[k][11:0]);
        end
        clr_v = 1'b0;
        clr_m = '0;

        // R1: reset in the middle of operation
        rst_ni = 1'b0;
        @(negedge clk);
        check(1, 12'h000);
        rst_ni  = 1'b1;
        fall_en = 6'h3F;
        rise_en = 6'h3F;
        deb     = 16'd0;

        // R11: D = 0
        pins = 6'h3F; step(); check(11, 12'h000);
        pins = 6'h3E; step(); check(11, 12'h000);
        step();               check(11, 12'h001);

        // R10: two pins qualify in the same cycle
        pins = 6'h38; step(); check(10, 12'h001);
        step();               check(10, 12'h007);

        // R6: D = 5, last short edge then qualify
        clr_v = 1'b1; clr_m = 12'h007;
        step();               check(7, 12'h000);
        clr_v = 1'b0; clr_m = '0;
        deb  = 16'd5;
        pins = 6'h39;
        for (int n = 0; n < 6; n++) begin
            step();
            check(6, 12'h000);
        end
        step();               check(6, 12'h040);

        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

endmodule